// File: doc/BRIEF.md
# Supply-Line Pulse Programming Controller

This block turns a supply pin that steps between three voltage levels into the program path for a one-time-programmable switchpoint trim. An external comparator stage has already classified each clock sample of the supply as low (idle), mid or high. The block measures every excursion above the idle level and classifies it by level and duration. From the resulting stream it recognises two protection keys and counts addressing pulses into a volatile trial address. When a fuse-blow pulse arrives under the right conditions, it issues a single-cycle blow strobe together with the index of the fuse to blow.

A fuse shadow register records every blow that is issued: seven switchpoint code bits, a polarity-range bit and a lock bit. The trial address lets a tester sweep the switchpoint before anything is made permanent. Once the lock fuse is blown, no further strobe can be produced. Loss of the power-good input throws away all volatile programming state and leaves the shadow register untouched.

Top module: `supply_prog_ctrl`

## Requirements
- R1: An excursion of the supply above low is one pulse. A pulse with fewer than MIN_ON cycles (default 20) has no effect. A pulse that contains at least one high sample counts as a high pulse, otherwise as a mid pulse. Level encoding: 2'b00 low, 2'b01 mid, 2'b1x high.
- R2: A high pulse shorter than BLOW_MIN cycles (default 100) with no sequence open opens one and sets trial_addr to 1. Each later mid pulse adds one, saturating at 128. Mid pulses outside an open sequence are ignored.
- R3: A short high pulse that follows a high pulse and 1 to 6 mid pulses, when the negative range is not yet selected, sets trial_neg. The same pulse restarts addressing at trial_addr = 1.
- R4: When not armed, a short high pulse that follows a high pulse and 7 or more mid pulses sets prog_armed and clears trial_addr to 0.
- R5: A short high pulse whose preceding mid count fits neither key window (for example zero mids) returns the decoder to idle: trial_addr becomes 0 and no key is set.
- R6: A high pulse of BLOW_MIN to BLOW_MAX cycles (default 100 to 300) while armed, with trial_addr equal to 2^k for k in 0..6, gives one blow_stb cycle with blow_idx = k. Fuse code bit k is then set. After any such pulse, prog_armed and trial_addr read 0.
- R7: A blow-width pulse while armed, with no sequence open and trial_neg set, gives blow_idx = 7 and sets fuse_pol.
- R8: A blow-width pulse while armed at trial_addr = 128 gives blow_idx = 8 and sets fuse_lock. After that, no blow_stb occurs again and the fuse outputs stay as they are.
- R9: Addressing and keys alone never strobe. A blow-width pulse while unarmed, or armed at an address that is not a single code bit or 128, produces no strobe.
- R10: A high pulse longer than BLOW_MAX cycles gives one width_err cycle and no strobe. It also clears prog_armed and trial_addr.
- R11: When pwr_good is low, trial_addr, trial_neg and prog_armed are 0 on the next cycle. The fuse outputs keep their values.
- R12: Synchronous reset clears all outputs, including the fuse shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply valid; low discards volatile state |
| sup_lvl | input | 2 | Classified supply level: 00 low, 01 mid, 1x high |
| trial_addr | output | 8 | Current trial address, 0 when no sequence is open, 128 is the lock address |
| trial_neg | output | 1 | Negative addressing range selected |
| prog_armed | output | 1 | Program-enable key accepted |
| blow_stb | output | 1 | One-cycle fuse blow request |
| blow_idx | output | 4 | Fuse to blow: 0..6 code bit, 7 polarity, 8 lock |
| width_err | output | 1 | One-cycle flag for an over-long high pulse |
| fuse_code | output | 7 | Shadow of the blown code bits |
| fuse_pol | output | 1 | Shadow of the polarity-range fuse |
| fuse_lock | output | 1 | Shadow of the lock fuse |

## Verification
A wrong mid count or key flag inside the decoder first shows on trial_addr, trial_neg or prog_armed. It appears two cycles after the supply returns to low at the end of the pulse that went wrong, so the bench reads these ports after every sequence and not only at the end. A misrouted blow shows as a wrong blow_idx on the strobe cycle and as a wrong bit in the fuse shadow one cycle later. A lock or arming fault shows as an extra or missing strobe that the bench counts directly.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int CODE_BITS = 7;
    localparam int ADDR_W    = CODE_BITS + 1;
    localparam int NFUSE     = CODE_BITS + 2;
    localparam int IDX_W     = $clog2(NFUSE);
    localparam int IDX_POL   = CODE_BITS;
    localparam int IDX_LOCK  = CODE_BITS + 1;
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(1 << CODE_BITS);

    typedef enum logic [1:0] {
        PK_MID   = 2'd0,
        PK_KEY   = 2'd1,
        PK_BLOW  = 2'd2,
        PK_OVER  = 2'd3
    } pkind_e;

    typedef struct packed {
        logic   valid;
        pkind_e kind;
    } pulse_ev_t;

    function automatic logic lvl_active(input logic [1:0] l);
        return l != 2'b00;
    endfunction

    function automatic logic lvl_high(input logic [1:0] l);
        return l[1];
    endfunction

    // Returns 1 when addr selects exactly one code bit; idx gets its weight.
    function automatic logic code_bit_of(input logic [ADDR_W-1:0] addr,
                                         output logic [IDX_W-1:0] idx);
        logic hit;
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < CODE_BITS; i++) begin
            if (addr == ADDR_W'(1 << i)) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
        return hit;
    endfunction

endpackage

// File: rtl/spc_pulse_meas.sv
module spc_pulse_meas
    import spc_pkg::*;
#(
    parameter int MIN_ON   = 20,
    parameter int BLOW_MIN = 100,
    parameter int BLOW_MAX = 300
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_good,
    input  logic [1:0]  sup_lvl,
    output pulse_ev_t   ev
);
    localparam int WID_W = $clog2(BLOW_MAX + 2);
    localparam logic [WID_W-1:0] WID_SAT = WID_W'(BLOW_MAX + 1);

    logic             run;
    logic             saw_high;
    logic [WID_W-1:0] width;

    function automatic pkind_e classify(input logic hi, input logic [WID_W-1:0] w);
        if (!hi)                         return PK_MID;
        else if (w < WID_W'(BLOW_MIN))   return PK_KEY;
        else if (w <= WID_W'(BLOW_MAX))  return PK_BLOW;
        else                             return PK_OVER;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || !pwr_good) begin
            run      <= 1'b0;
            saw_high <= 1'b0;
            width    <= '0;
            ev       <= '{valid: 1'b0, kind: PK_MID};
        end else begin
            ev.valid <= 1'b0;
            if (lvl_active(sup_lvl)) begin
                if (!run) begin
                    run      <= 1'b1;
                    width    <= WID_W'(1);
                    saw_high <= lvl_high(sup_lvl);
                end else begin
                    if (width != WID_SAT)
                        width <= width + 1'b1;
                    saw_high <= saw_high | lvl_high(sup_lvl);
                end
            end else if (run) begin
                run <= 1'b0;
                if (width >= WID_W'(MIN_ON)) begin
                    ev.valid <= 1'b1;
                    ev.kind  <= classify(saw_high, width);
                end
            end
        end
    end

endmodule

// File: rtl/spc_key_decoder.sv
module spc_key_decoder
    import spc_pkg::*;
#(
    parameter int PE_MIN_MIDS  = 7,
    parameter int POL_MAX_MIDS = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_good,
    input  pulse_ev_t          ev,
    input  logic               locked,
    output logic [ADDR_W-1:0]  trial_addr,
    output logic               trial_neg,
    output logic               prog_armed,
    output logic               blow_stb,
    output logic [IDX_W-1:0]   blow_idx,
    output logic               width_err
);
    logic              in_seq;
    logic              pol;
    logic              pe;
    logic [ADDR_W-1:0] addr;
    logic              bit_hit;
    logic [IDX_W-1:0]  bit_idx;

    always_comb begin
        bit_hit = code_bit_of(addr, bit_idx);
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_good) begin
            in_seq    <= 1'b0;
            pol       <= 1'b0;
            pe        <= 1'b0;
            addr      <= '0;
            blow_stb  <= 1'b0;
            blow_idx  <= '0;
            width_err <= 1'b0;
        end else begin
            blow_stb  <= 1'b0;
            width_err <= 1'b0;
            if (ev.valid) begin
                unique case (ev.kind)
                    PK_MID: begin
                        if (in_seq && addr != LOCK_ADDR)
                            addr <= addr + 1'b1;
                    end
                    PK_KEY: begin
                        if (!in_seq || pe) begin
                            in_seq <= 1'b1;
                            addr   <= ADDR_W'(1);
                        end else if (addr > ADDR_W'(PE_MIN_MIDS)) begin
                            pe     <= 1'b1;
                            in_seq <= 1'b0;
                            addr   <= '0;
                        end else if (!pol && addr >= ADDR_W'(2)
                                     && addr <= ADDR_W'(POL_MAX_MIDS + 1)) begin
                            pol  <= 1'b1;
                            addr <= ADDR_W'(1);
                        end else begin
                            in_seq <= 1'b0;
                            addr   <= '0;
                        end
                    end
                    PK_BLOW: begin
                        if (pe && !locked) begin
                            if (in_seq && addr == LOCK_ADDR) begin
                                blow_stb <= 1'b1;
                                blow_idx <= IDX_W'(IDX_LOCK);
                            end else if (in_seq && bit_hit) begin
                                blow_stb <= 1'b1;
                                blow_idx <= bit_idx;
                            end else if (!in_seq && pol) begin
                                blow_stb <= 1'b1;
                                blow_idx <= IDX_W'(IDX_POL);
                            end
                        end
                        pe     <= 1'b0;
                        in_seq <= 1'b0;
                        addr   <= '0;
                    end
                    PK_OVER: begin
                        width_err <= 1'b1;
                        pe        <= 1'b0;
                        in_seq    <= 1'b0;
                        addr      <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign trial_addr = addr;
    assign trial_neg  = pol;
    assign prog_armed = pe;

endmodule

// File: rtl/spc_fuse_shadow.sv
module spc_fuse_shadow
    import spc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             blow_stb,
    input  logic [IDX_W-1:0] blow_idx,
    output logic [NFUSE-1:0] fuses
);
    for (genvar i = 0; i < NFUSE; i++) begin : g_fuse
        always_ff @(posedge clk) begin
            if (rst)
                fuses[i] <= 1'b0;
            else if (blow_stb && blow_idx == IDX_W'(i))
                fuses[i] <= 1'b1;
        end
    end

endmodule

// File: rtl/supply_prog_ctrl.sv
module supply_prog_ctrl
    import spc_pkg::*;
#(
    parameter int MIN_ON       = 20,
    parameter int BLOW_MIN     = 100,
    parameter int BLOW_MAX     = 300,
    parameter int PE_MIN_MIDS  = 7,
    parameter int POL_MAX_MIDS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pwr_good,
    input  logic [1:0]           sup_lvl,
    output logic [ADDR_W-1:0]    trial_addr,
    output logic                 trial_neg,
    output logic                 prog_armed,
    output logic                 blow_stb,
    output logic [IDX_W-1:0]     blow_idx,
    output logic                 width_err,
    output logic [CODE_BITS-1:0] fuse_code,
    output logic                 fuse_pol,
    output logic                 fuse_lock
);
    pulse_ev_t        ev;
    logic [NFUSE-1:0] fuses;

    spc_pulse_meas #(
        .MIN_ON   (MIN_ON),
        .BLOW_MIN (BLOW_MIN),
        .BLOW_MAX (BLOW_MAX)
    ) u_meas (
        .clk      (clk),
        .rst      (rst),
        .pwr_good (pwr_good),
        .sup_lvl  (sup_lvl),
        .ev       (ev)
    );

    spc_key_decoder #(
        .PE_MIN_MIDS  (PE_MIN_MIDS),
        .POL_MAX_MIDS (POL_MAX_MIDS)
    ) u_dec (
        .clk        (clk),
        .rst        (rst),
        .pwr_good   (pwr_good),
        .ev         (ev),
        .locked     (fuses[IDX_LOCK]),
        .trial_addr (trial_addr),
        .trial_neg  (trial_neg),
        .prog_armed (prog_armed),
        .blow_stb   (blow_stb),
        .blow_idx   (blow_idx),
        .width_err  (width_err)
    );

    spc_fuse_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .blow_stb (blow_stb),
        .blow_idx (blow_idx),
        .fuses    (fuses)
    );

    assign fuse_code = fuses[CODE_BITS-1:0];
    assign fuse_pol  = fuses[IDX_POL];
    assign fuse_lock = fuses[IDX_LOCK];

endmodule

// File: rtl/spc_checker.sv
module spc_checker
    import spc_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 pwr_good,
    input logic [ADDR_W-1:0]    trial_addr,
    input logic                 trial_neg,
    input logic                 prog_armed,
    input logic                 blow_stb,
    input logic [IDX_W-1:0]     blow_idx,
    input logic                 width_err,
    input logic [CODE_BITS-1:0] fuse_code,
    input logic                 fuse_pol,
    input logic                 fuse_lock
);
    a_r2_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        trial_addr <= LOCK_ADDR);

    a_r6_code_bit_lands: assert property (@(posedge clk) disable iff (rst)
        (blow_stb && blow_idx < IDX_W'(CODE_BITS))
        |=> ((fuse_code >> $past(blow_idx)) & 1) == 1);

    a_r6_idx_legal: assert property (@(posedge clk) disable iff (rst)
        blow_stb |-> blow_idx <= IDX_W'(IDX_LOCK));

    a_r8_no_blow_when_locked: assert property (@(posedge clk) disable iff (rst)
        blow_stb |-> !$past(fuse_lock));

    a_r8_lock_sticks: assert property (@(posedge clk) disable iff (rst)
        fuse_lock |=> fuse_lock);

    a_r10_err_not_blow: assert property (@(posedge clk) disable iff (rst)
        width_err |-> !blow_stb);

    a_r11_pg_clears: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (trial_addr == '0 && !trial_neg && !prog_armed));

    a_r11_fuses_monotonic: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(fuse_code) & ~fuse_code) == '0
                  && (!$past(fuse_pol) || fuse_pol)));

    a_r12_reset_clears: assert property (@(posedge clk)
        rst |=> (fuse_code == '0 && !fuse_pol && !fuse_lock
                 && !blow_stb && trial_addr == '0));

endmodule

bind supply_prog_ctrl spc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwr_good   (pwr_good),
    .trial_addr (trial_addr),
    .trial_neg  (trial_neg),
    .prog_armed (prog_armed),
    .blow_stb   (blow_stb),
    .blow_idx   (blow_idx),
    .width_err  (width_err),
    .fuse_code  (fuse_code),
    .fuse_pol   (fuse_pol),
    .fuse_lock  (fuse_lock)
);

// File: tb/supply_prog_ctrl_test.sv
module supply_prog_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] LO = 2'b00, MD = 2'b01, HI = 2'b10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_good = 1'b1;
    logic [1:0] sup_lvl = LO;
    logic [7:0] trial_addr;
    logic       trial_neg, prog_armed, blow_stb, width_err;
    logic [3:0] blow_idx;
    logic [6:0] fuse_code;
    logic       fuse_pol, fuse_lock;

    int n_chk = 0, n_bad = 0;
    int stb_cnt = 0, err_cnt = 0, last_idx = -1;
    bit done = 0;
    logic [6:0] exp_code = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supply_prog_ctrl uut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .sup_lvl(sup_lvl),
        .trial_addr(trial_addr), .trial_neg(trial_neg), .prog_armed(prog_armed),
        .blow_stb(blow_stb), .blow_idx(blow_idx), .width_err(width_err),
        .fuse_code(fuse_code), .fuse_pol(fuse_pol), .fuse_lock(fuse_lock)
    );

    always @(negedge clk) begin
        if (blow_stb) begin stb_cnt++; last_idx = int'(blow_idx); end
        if (width_err) err_cnt++;
    end

    function automatic int exp_addr(input int mids);
        return (mids + 1 > 128) ? 128 : mids + 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [1:0] k, input int w);
        @(negedge clk) sup_lvl = k;
        repeat (w - 1) @(negedge clk);
        @(negedge clk) sup_lvl = LO;
        repeat (20) @(negedge clk);
    endtask

    task automatic mids(input int n);
        for (int i = 0; i < n; i++) pulse(MD, 20);
    endtask

    task automatic prog_en();
        pulse(HI, 40); mids(8); pulse(HI, 40);
    endtask

    task automatic pg_drop();
        @(negedge clk) pwr_good = 1'b0;
        repeat (3) @(negedge clk);
        pwr_good = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic blow_bit(input int b);
        int s0;
        s0 = stb_cnt;
        prog_en();
        pulse(HI, 40); mids((1 << b) - 1);
        pulse(HI, 150);
        exp_code[b] = 1'b1;
        chk("R6 strobe count", stb_cnt - s0, 1);
        chk("R6 blow_idx", last_idx, b);
        chk("R6 fuse_code", int'(fuse_code), int'(exp_code));
        chk("R6 armed cleared", int'(prog_armed), 0);
    endtask

    initial begin
        int s0, e0;
        void'($urandom(32'h5a17));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk("R12 trial_addr", int'(trial_addr), 0);
        chk("R12 fuses", int'({fuse_lock, fuse_pol, fuse_code}), 0);
        chk("R12 armed/neg", int'({prog_armed, trial_neg}), 0);

        // R1: short glitches ignored
        pulse(HI, 10); pulse(MD, 12);
        chk("R1 glitch ignored", int'(trial_addr), 0);

        // R2: addressing
        pulse(HI, 40);
        chk("R2 first address", int'(trial_addr), 1);
        mids(3);
        chk("R2 three mids", int'(trial_addr), 4);

        // R1 + R3: mixed mid-then-high pulse counts as high, completes polarity key
        @(negedge clk) sup_lvl = MD;
        repeat (10) @(negedge clk);
        sup_lvl = HI;
        repeat (30) @(negedge clk);
        sup_lvl = LO;
        repeat (20) @(negedge clk);
        chk("R3 trial_neg", int'(trial_neg), 1);
        chk("R3 address restarts", int'(trial_addr), 1);

        // R11: power-good loss
        pg_drop();
        chk("R11 addr cleared", int'(trial_addr), 0);
        chk("R11 neg cleared", int'(trial_neg), 0);

        // R5: zero mids between highs -> idle
        pulse(HI, 40); pulse(HI, 40);
        chk("R5 idle addr", int'(trial_addr), 0);
        chk("R5 no key", int'({prog_armed, trial_neg}), 0);

        // R4: program enable, then R9 blow with nothing addressed
        prog_en();
        chk("R4 armed", int'(prog_armed), 1);
        chk("R4 addr zero", int'(trial_addr), 0);
        s0 = stb_cnt;
        pulse(HI, 150);
        chk("R9 no target no strobe", stb_cnt - s0, 0);
        chk("R9 armed consumed", int'(prog_armed), 0);

        // R9: unarmed blow
        pulse(HI, 40); mids(1);
        pulse(HI, 150);
        chk("R9 unarmed no strobe", stb_cnt - s0, 0);
        chk("R9 fuses untouched", int'(fuse_code), 0);

        // R6: code 5 as bit 0 then bit 2
        blow_bit(0);
        blow_bit(2);

        // R9: address 3 is not a single bit
        s0 = stb_cnt;
        prog_en(); pulse(HI, 40); mids(2);
        pulse(HI, 150);
        chk("R9 non-bit address", stb_cnt - s0, 0);

        // R10: over-long high
        e0 = err_cnt;
        prog_en(); pulse(HI, 40);
        pulse(HI, 320);
        chk("R10 width_err", err_cnt - e0, 1);
        chk("R10 no strobe", stb_cnt - s0, 0);
        chk("R10 armed cleared", int'({prog_armed, (trial_addr != 0)}), 0);

        // R7: polarity key then program enable sharing a high, then blow
        pg_drop();
        pulse(HI, 40); mids(2); pulse(HI, 40);
        chk("R3 key before enable", int'(trial_neg), 1);
        mids(8); pulse(HI, 40);
        chk("R4 armed after pol key", int'(prog_armed), 1);
        pulse(HI, 150);
        chk("R7 strobe", stb_cnt - s0, 1);
        chk("R7 blow_idx", last_idx, 7);
        chk("R7 fuse_pol", int'(fuse_pol), 1);

        // R11: interrupted enable key does not arm
        pg_drop();
        pulse(HI, 40); mids(4); pg_drop(); mids(4); pulse(HI, 40);
        chk("R11 interrupted key", int'(prog_armed), 0);
        chk("R11 fuses kept", int'({fuse_pol, fuse_code}), int'({1'b1, exp_code}));

        // R2: random addressing lengths
        for (int it = 0; it < 12; it++) begin
            int m;
            pg_drop();
            m = (it == 0) ? 130 : int'($urandom_range(0, 135));
            pulse(HI, 40); mids(m);
            chk("R2 random address", int'(trial_addr), exp_addr(m));
        end

        // R6: random code bits
        for (int it = 0; it < 3; it++) begin
            pg_drop();
            blow_bit(int'($urandom_range(0, 5)));
        end

        // R8: lock, then nothing more
        pg_drop();
        s0 = stb_cnt;
        prog_en(); pulse(HI, 40); mids(127);
        chk("R8 lock address", int'(trial_addr), 128);
        pulse(HI, 150);
        chk("R8 lock strobe", stb_cnt - s0, 1);
        chk("R8 lock idx", last_idx, 8);
        chk("R8 fuse_lock", int'(fuse_lock), 1);
        prog_en(); pulse(HI, 40); mids(63);
        pulse(HI, 150);
        chk("R8 ignored after lock", stb_cnt - s0, 1);
        chk("R8 code unchanged", int'(fuse_code), int'(exp_code));

        // R12: reset clears shadow
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk("R12 shadow cleared", int'({fuse_lock, fuse_pol, fuse_code}), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule